// File: doc/BRIEF.md
# Function-Coded ALU with Saved End Carry

This block is a registered arithmetic and logic stage for a 16-bit datapath. Each cycle it combines two operands, A and B, under a 4-bit function code. The outcome can be written into a result register, and that register places its value on a shared result bus while an output-enable is held high. The function set is small and fixed: pass either operand, two exclusive-OR forms, and two adder forms. One adder form adds with a forced carry-in of one. The other adds the complement of B with a carry-in of zero, which gives A − B − 1.

The carry out of the top bit is the end carry. It is captured in a separate saved-carry flag, under its own capture enable. A branch or test circuit reads the flag through an active-low output. The result register and the flag load independently, so a carry can be kept while later results move through the result register.

The external reset is asynchronous and active low. Inside the block, its release is synchronised to the clock.

Top module: `alu_sc_top`

## Requirements
- R1: Function code 1 (4'b0001) loads A unchanged into the result register.
- R2: Function code 0 (4'b0000) loads B unchanged into the result register.
- R3: Function code 4 (4'b0100) loads A XOR B.
- R4: Function code 7 (4'b0111) loads A XOR (NOT B).
- R5: Function code 10 (4'b1010) loads the low 16 bits of A + B + 1, and its end carry is the carry out of bit 15 of that sum.
- R6: Function code 13 (4'b1101) loads the low 16 bits of A + (NOT B) with a carry-in of 0, and its end carry is the carry out of bit 15.
- R7: For codes 0, 1, 4 and 7 the end carry is 0. Every code not listed in R1–R6 gives a result of zero and an end carry of 0.
- R8: The result register loads the ALU output only on a rising clock edge with `res_ce` high. Otherwise it holds its value.
- R9: The saved-carry flag loads the end carry only on a rising clock edge with `cy_ce` high. `test_n` is the inverse of the flag, so `test_n` is 0 when the stored carry is 1.
- R10: `res_bus` shows the result register and `res_bus_drv` is 1 while `res_oe` is 1. While `res_oe` is 0, `res_bus` is all zeros and `res_bus_drv` is 0.
- R11: While reset is asserted, the result register and the saved-carry flag are 0, so `test_n` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| fn_code | input | 4 | Function select |
| res_ce | input | 1 | Result register load enable |
| cy_ce | input | 1 | Saved-carry load enable |
| res_oe | input | 1 | Result bus output enable |
| res_bus | output | 16 | Result bus data, zero when not driven |
| res_bus_drv | output | 1 | High while the block drives the bus |
| test_n | output | 1 | Inverted saved carry |

## Verification
Any corruption inside the block shows up at the outputs within one clock edge.

- A wrong result register, or a wrong adder bit, appears on `res_bus` one edge after the load.
- A broken carry chain shows in the sum and in `test_n`. Walking-one operands place the carry boundary at every bit position, so a broken link at any position is caught.
- A flag that loads without its enable, or that fails to hold, shows as a `test_n` change on the edge where none is expected.

// File: rtl/alu_sc_pkg.sv
package alu_sc_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned FN_W   = 4;

  typedef enum logic [FN_W-1:0] {
    FN_PASS_B   = 4'd0,
    FN_PASS_A   = 4'd1,
    FN_XOR      = 4'd4,
    FN_XOR_NB   = 4'd7,
    FN_ADD_INC  = 4'd10,
    FN_ADD_NB   = 4'd13
  } alu_fn_e;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_sc_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned FW = FN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [FW-1:0] fn,
  output logic [W-1:0]  y,
  output logic          end_cy
);
  logic         inv_b;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W:0]   cy;

  // Operand conditioning shared by the XOR and adder forms
  always_comb begin
    inv_b = (fn == FN_XOR_NB) || (fn == FN_ADD_NB);
    cin   = (fn == FN_ADD_INC);
  end

  assign b_eff = b ^ {W{inv_b}};
  assign cy[0] = cin;

  // Ripple chain, one full adder per bit
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum[k]  = a[k] ^ b_eff[k] ^ cy[k];
    assign cy[k+1] = (a[k] & b_eff[k]) | (cy[k] & (a[k] ^ b_eff[k]));
  end

  always_comb begin
    y      = '0;
    end_cy = 1'b0;
    case (fn)
      FN_PASS_B:            y = b;
      FN_PASS_A:            y = a;
      FN_XOR, FN_XOR_NB:    y = a ^ b_eff;
      FN_ADD_INC, FN_ADD_NB: begin
        y      = sum;
        end_cy = cy[W];
      end
      default: begin
        y      = '0;
        end_cy = 1'b0;
      end
    endcase
  end

  // R5
  add_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_ADD_INC) |-> ({end_cy, y} == ({1'b0, a} + {1'b0, b} + (W+1)'(1))));

  // R6
  add_nb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_ADD_NB) |-> ({end_cy, y} == ({1'b0, a} + {1'b0, ~b})));

  // R7
  unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn inside {FN_PASS_B, FN_PASS_A, FN_XOR, FN_XOR_NB, FN_ADD_INC, FN_ADD_NB})
      |-> (y == '0 && !end_cy));
endmodule

// File: rtl/alu_result_reg.sv
module alu_result_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));

  // R8
  res_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q == $past(d)));
endmodule

// File: rtl/alu_carry_flag.sv
module alu_carry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic cy_in,
  output logic test_n
);
  logic saved_q;
  logic saved_nxt;

  always_comb begin
    saved_nxt = saved_q;
    if (ce) begin
      saved_nxt = cy_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= 1'b0;
    end else begin
      saved_q <= saved_nxt;
    end
  end

  assign test_n = ~saved_q;

  // R9
  cy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (saved_q == $past(cy_in)));

  // R9
  cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(saved_q));
endmodule

// File: rtl/alu_sc_top.sv
module alu_sc_top
  import alu_sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [3:0]  fn_code,
  input  logic        res_ce,
  input  logic        cy_ce,
  input  logic        res_oe,
  output logic [15:0] res_bus,
  output logic        res_bus_drv,
  output logic        test_n
);
  localparam int unsigned W  = DATA_W;
  localparam int unsigned FW = FN_W;

  logic         rst_i_n;
  logic [W-1:0] alu_y;
  logic         alu_cy;
  logic [W-1:0] res_q;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  alu_func_unit #(.W(W), .FW(FW)) u_fu (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .a      (op_a),
    .b      (op_b),
    .fn     (fn_code),
    .y      (alu_y),
    .end_cy (alu_cy)
  );

  alu_result_reg #(.W(W)) u_res (
    .clk   (clk),
    .rst_n (rst_i_n),
    .ce    (res_ce),
    .d     (alu_y),
    .q     (res_q)
  );

  alu_carry_flag u_cy (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ce     (cy_ce),
    .cy_in  (alu_cy),
    .test_n (test_n)
  );

  always_comb begin
    res_bus     = res_oe ? res_q : '0;
    res_bus_drv = res_oe;
  end
endmodule

// File: tb/sim_alu_sc_top.sv
module sim_alu_sc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [3:0]  fn_code;
  logic        res_ce, cy_ce, res_oe;
  logic [15:0] res_bus;
  logic        res_bus_drv, test_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_sc_top u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fn_code(fn_code),
    .res_ce(res_ce), .cy_ce(cy_ce), .res_oe(res_oe),
    .res_bus(res_bus), .res_bus_drv(res_bus_drv), .test_n(test_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one operation; the result is visible at the following falling edge
  task automatic op(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b,
                    input logic rce, input logic cce);
    @(negedge clk);
    fn_code = f; op_a = a; op_b = b; res_ce = rce; cy_ce = cce;
    @(negedge clk);
    res_ce = 1'b0; cy_ce = 1'b0;
  endtask

  task automatic run_chk(input string req, input logic [3:0] f, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] exp_y, input logic exp_cy);
    op(f, a, b, 1'b1, 1'b1);
    chk(req, {16'h0, res_bus}, {16'h0, exp_y});
    chk(req, {31'h0, test_n}, {31'h0, ~exp_cy});
  endtask

  task automatic t_reset;
    // R11: during reset, bus shows zero, test_n high
    res_oe = 1'b1; res_ce = 1'b1; cy_ce = 1'b1;
    fn_code = 4'd1; op_a = 16'hFFFF; op_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R11", {16'h0, res_bus}, 32'h0);
    chk("R11", {31'h0, test_n}, 32'h1);
    res_ce = 1'b0; cy_ce = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pass;
    run_chk("R1", 4'd1, 16'hA5C3, 16'h1234, 16'hA5C3, 1'b0);
    run_chk("R1", 4'd1, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0);
    run_chk("R2", 4'd0, 16'hA5C3, 16'h1234, 16'h1234, 1'b0);
    run_chk("R2", 4'd0, 16'h0000, 16'h8001, 16'h8001, 1'b0);
  endtask

  task automatic t_xor;
    for (int j = 0; j < 16; j++) begin
      logic [15:0] a;
      a = 16'h1 << j;
      run_chk("R3", 4'd4, a, 16'h0000, a, 1'b0);
      run_chk("R4", 4'd7, a, 16'h0000, ~a, 1'b0);
    end
    run_chk("R3", 4'd4, 16'hF0F0, 16'h3C3C, 16'hCCCC, 1'b0);
    run_chk("R4", 4'd7, 16'hF0F0, 16'h3C3C, 16'h3333, 1'b0);
  endtask

  task automatic t_add;
    for (int i = 0; i <= 16; i++) begin
      logic [16:0] a17;
      logic [15:0] a, am1;
      logic [16:0] s;
      a17 = 17'h1 << i;
      a   = a17[15:0];
      am1 = 16'(a17 - 17'h1);
      // R5 carry propagates from bit 0 up to bit i
      s = {1'b0, am1} + 17'h1;
      run_chk("R5", 4'd10, am1, 16'h0000, s[15:0], s[16]);
      // R5 carry killed at bit i
      s = {1'b0, ~a} + 17'h1;
      run_chk("R5", 4'd10, ~a, 16'h0000, s[15:0], s[16]);
      // R6 A + ~0 = A - 1, carry out unless A is zero
      s = {1'b0, a} + {1'b0, 16'hFFFF};
      run_chk("R6", 4'd13, a, 16'h0000, s[15:0], s[16]);
    end
    run_chk("R5", 4'd10, 16'h1234, 16'h4321, 16'h5556, 1'b0);
    run_chk("R5", 4'd10, 16'h8000, 16'h7FFF, 16'h0000, 1'b1);
    run_chk("R6", 4'd13, 16'h0005, 16'h0003, 16'h0001, 1'b1);
    run_chk("R6", 4'd13, 16'h0003, 16'h0005, 16'hFFFD, 1'b0);
    run_chk("R6", 4'd13, 16'h0007, 16'h0007, 16'hFFFF, 1'b0);
  endtask

  task automatic t_unlisted;
    // R7: first load a carry of 1, then unlisted codes must clear it and give 0
    for (int c = 0; c < 16; c++) begin
      if (c inside {0, 1, 4, 7, 10, 13}) continue;
      op(4'd10, 16'hFFFF, 16'h0000, 1'b1, 1'b1);
      chk("R7", {31'h0, test_n}, 32'h0);
      run_chk("R7", 4'(c), 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0);
    end
  endtask

  task automatic t_hold;
    op(4'd1, 16'h5A5A, 16'h0, 1'b1, 1'b0);
    chk("R8", {16'h0, res_bus}, 32'h5A5A);
    op(4'd1, 16'h1111, 16'h0, 1'b0, 1'b0);
    chk("R8", {16'h0, res_bus}, 32'h5A5A);
    op(4'd10, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    chk("R8", {16'h0, res_bus}, 32'h5A5A);
  endtask

  task automatic t_flag;
    op(4'd10, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
    chk("R9", {31'h0, test_n}, 32'h0);
    chk("R9", {16'h0, res_bus}, 32'h5A5A);
    // no capture: carry of 0 must not reach the flag
    op(4'd1, 16'h0000, 16'h0000, 1'b1, 1'b0);
    chk("R9", {31'h0, test_n}, 32'h0);
    op(4'd1, 16'h0000, 16'h0000, 1'b0, 1'b1);
    chk("R9", {31'h0, test_n}, 32'h1);
  endtask

  task automatic t_bus;
    op(4'd0, 16'h0, 16'hBEEF, 1'b1, 1'b0);
    res_oe = 1'b0;
    #1;
    chk("R10", {16'h0, res_bus}, 32'h0);
    chk("R10", {31'h0, res_bus_drv}, 32'h0);
    res_oe = 1'b1;
    #1;
    chk("R10", {16'h0, res_bus}, 32'hBEEF);
    chk("R10", {31'h0, res_bus_drv}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; fn_code = '0;
    res_ce = 1'b0; cy_ce = 1'b0; res_oe = 1'b1;
    t_reset();
    t_pass();
    t_xor();
    t_add();
    t_unlisted();
    t_hold();
    t_flag();
    t_bus();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule